// File: doc/BRIEF.md
# PWM Short-Pulse Filter and Output Gate

This block conditions six PWM drive lines, an upper and a lower switch for each of three phases, before they leave the chip. Each line has its own width filter. The filter suppresses any high pulse that does not last longer than a programmable minimum width. Wider pulses pass, but they come out later and shorter. The filter does not stretch short pulses; it drops them completely.

After the filters, an active-low gate input can force all six outputs low. The gate acts on the outputs only. The filters keep counting while the outputs are held off. When the gate opens again, the outputs show the present filtered state in the same cycle. This can emit a runt pulse, and downstream logic must tolerate it.

The filter works in clock samples. A line is sampled at each rising edge. Its registered filter output goes high once the input has been high for more than `min_width` consecutive samples. It stays high until the input is sampled low. There is one register of latency, so a pulse of W samples with W > `min_width` appears `min_width` + 1 edges after its first high sample and lasts W − `min_width` cycles.

Top module: `pwm_pulse_cleaner`

## Requirements
- R1: A high pulse lasting W consecutive samples with W ≤ `min_width` never drives the corresponding output high.
- R2: A pulse of W samples with W > `min_width` drives its output high from the edge `min_width` clocks after its first high sample, for exactly W − `min_width` cycles.
- R3: With `min_width` = 0, each output equals its input delayed by one clock, so single-sample pulses pass.
- R4: While `outputs_on` is 0, all six outputs are low.
- R5: The filters keep running while `outputs_on` is 0. When `outputs_on` returns to 1, the outputs show the current filtered state in that same cycle, without waiting for a clock. This may produce a pulse shorter than `min_width`.
- R6: A synchronous active-high `rst` clears every filter's count and forces all outputs low from the next edge. A line that is still high after reset must again be high for more than `min_width` samples before its output rises.
- R7: The six lines are filtered independently. Bit 2p of `pwm_raw` and `pwm_out` is the upper switch of phase p, and bit 2p+1 is the lower switch.
- R8: The width count saturates at its maximum, so with `min_width` = 255 a pulse of 300 samples passes for 45 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything samples on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pwm_raw | input | 6 | Unfiltered PWM lines, upper/lower pair per phase |
| min_width | input | 8 | Deletion threshold in clock samples; 0 passes every pulse |
| outputs_on | input | 1 | Active-low inhibit: 0 holds all outputs low, 1 passes the filtered lines |
| pwm_out | output | 6 | Conditioned PWM lines |

## Verification
The bench builds the block with its default three phases and 8-bit count. At these settings the largest threshold, 255, and count saturation on a 300-sample pulse can be reached in a few hundred cycles. The bench's reference model tracks unbounded run lengths in its own way. Against that model it compares every cycle: pulses below, at and just above the threshold, mixed widths on different lines, a zero threshold, runt pulses released by the gate, and a reset that lands in the middle of a pulse.

// File: rtl/pdi_pkg.sv
package pdi_pkg;

  localparam int unsigned PDI_PHASES = 3;
  localparam int unsigned PDI_CNT_W  = 8;

  // Saturating increment of a run-length count.
  function automatic int unsigned run_step(input int unsigned run, input int unsigned top);
    return (run >= top) ? top : run + 1;
  endfunction

  // The filter passes a sample once the samples seen before it reach the threshold.
  function automatic logic width_met(input int unsigned run, input int unsigned thresh);
    return run >= thresh;
  endfunction

endpackage

// File: rtl/pdi_width_filter.sv
module pdi_width_filter #(
  parameter int unsigned CNT_W = pdi_pkg::PDI_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             raw,
  input  logic [CNT_W-1:0] min_w,
  output logic             filt
);
  localparam int unsigned RUN_MAX = (1 << CNT_W) - 1;

  logic [CNT_W-1:0] run_q;
  logic             filt_q;
  logic             pass_now;
  logic [CNT_W-1:0] run_nxt;

  assign pass_now = pdi_pkg::width_met(32'(run_q), 32'(min_w));
  assign run_nxt  = CNT_W'(pdi_pkg::run_step(32'(run_q), RUN_MAX));

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= '0;
      filt_q <= 1'b0;
    end else if (!raw) begin
      run_q  <= '0;
      filt_q <= 1'b0;
    end else begin
      run_q  <= run_nxt;
      filt_q <= pass_now;
    end
  end

  assign filt = filt_q;

  // R1/R2: a low sample always ends the filtered pulse at the next edge
  a_r1_low_clears: assert property (@(posedge clk) disable iff (rst)
    !raw |=> !filt);

  // R2: a high filtered output implies the input was high at the previous sample
  a_r2_high_needs_input: assert property (@(posedge clk) disable iff (rst)
    filt |-> $past(raw));

  // R1: with a nonzero threshold a single high sample cannot pass
  a_r1_single_blocked: assert property (@(posedge clk) disable iff (rst)
    (filt && $past(min_w) != '0) |-> $past(raw, 2));

  // R6: the output is low right after a reset edge
  a_r6_reset_low: assert property (@(posedge clk)
    $past(rst) |-> !filt);

endmodule

// File: rtl/pdi_out_gate.sv
module pdi_out_gate #(
  parameter int unsigned LINES = 2 * pdi_pkg::PDI_PHASES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] filt_bus,
  input  logic             on,
  output logic [LINES-1:0] drive
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    assign drive[g] = filt_bus[g] & on;
  end

  // R4: an off gate holds every line low
  a_r4_off_forces_low: assert property (@(posedge clk) disable iff (rst)
    !on |-> drive == '0);

  // R5: a high output always has a high filtered line behind it
  a_r5_no_spurious: assert property (@(posedge clk) disable iff (rst)
    (drive & ~filt_bus) == '0);

endmodule

// File: rtl/pwm_pulse_cleaner.sv
module pwm_pulse_cleaner #(
  parameter int unsigned PHASES = pdi_pkg::PDI_PHASES,
  parameter int unsigned CNT_W  = pdi_pkg::PDI_CNT_W,
  localparam int unsigned LINES = 2 * PHASES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] pwm_raw,
  input  logic [CNT_W-1:0] min_width,
  input  logic             outputs_on,
  output logic [LINES-1:0] pwm_out
);
  logic [LINES-1:0] filt_bus;

  for (genvar p = 0; p < PHASES; p++) begin : g_phase
    for (genvar s = 0; s < 2; s++) begin : g_side
      pdi_width_filter #(.CNT_W(CNT_W)) u_filt (
        .clk   (clk),
        .rst   (rst),
        .raw   (pwm_raw[2*p+s]),
        .min_w (min_width),
        .filt  (filt_bus[2*p+s])
      );
    end
  end

  pdi_out_gate #(.LINES(LINES)) u_gate (
    .clk      (clk),
    .rst      (rst),
    .filt_bus (filt_bus),
    .on       (outputs_on),
    .drive    (pwm_out)
  );

  // R6: reset drives all outputs low by the next edge
  a_r6_outputs_cleared: assert property (@(posedge clk)
    $past(rst) |-> pwm_out == '0);

endmodule

// File: tb/test_pwm_pulse_cleaner.sv
module test_pwm_pulse_cleaner;
  localparam time CLK_PERIOD = 10;
  localparam int  LINES = 6;

  typedef struct {
    logic [LINES-1:0] exp;
    string            req;
  } item_t;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [LINES-1:0] pwm_raw = '0;
  logic [7:0]       min_width = 8'd3;
  logic             outputs_on = 1'b1;
  logic [LINES-1:0] pwm_out;

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  item_t sb_q[$];
  int    run_len[LINES];

  pwm_pulse_cleaner i_pwm_pulse_cleaner (
    .clk(clk), .rst(rst), .pwm_raw(pwm_raw), .min_width(min_width),
    .outputs_on(outputs_on), .pwm_out(pwm_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Driver: apply one sample at the falling edge and predict the output after the next rise.
  task automatic step(input logic [LINES-1:0] v, input logic on, input logic r, input string req);
    item_t it;
    @(negedge clk);
    pwm_raw = v; outputs_on = on; rst = r;
    it.req = req;
    for (int i = 0; i < LINES; i++) begin
      if (r || !v[i]) begin
        run_len[i] = 0;
        it.exp[i] = 1'b0;
      end else begin
        run_len[i] = run_len[i] + 1;
        it.exp[i] = (run_len[i] > int'(min_width)) && on;
      end
    end
    sb_q.push_back(it);
  endtask

  task automatic hold(input logic [LINES-1:0] v, input logic on, input int n, input string req);
    for (int k = 0; k < n; k++) step(v, on, 1'b0, req);
  endtask

  // Monitor: compare a quarter period after each rising edge.
  initial begin
    forever begin
      item_t it;
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        checks++;
        if (pwm_out !== it.exp) begin
          errors++;
          $display("FAIL %s: pwm_out=%b expected=%b at %0t", it.req, pwm_out, it.exp, $time);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < LINES; i++) run_len[i] = 0;
    // R6: reset state
    for (int k = 0; k < 3; k++) step('0, 1'b1, 1'b1, "R6");
    hold('0, 1'b1, 2, "R6");
    // R1: pulses of 2 and 3 samples at threshold 3 are deleted
    hold(6'b000001, 1'b1, 2, "R1"); hold('0, 1'b1, 3, "R1");
    hold(6'b000001, 1'b1, 3, "R1"); hold('0, 1'b1, 3, "R1");
    // R2: 6 samples at threshold 3 give 3 cycles, delayed
    hold(6'b000001, 1'b1, 6, "R2"); hold('0, 1'b1, 5, "R2");
    hold(6'b000100, 1'b1, 4, "R2"); hold('0, 1'b1, 3, "R2");
    // R7: mixed widths on different lines
    hold(6'b111111, 1'b1, 2, "R7");
    hold(6'b101010, 1'b1, 4, "R7");
    hold(6'b100000, 1'b1, 3, "R7");
    hold('0, 1'b1, 4, "R7");
    // R3: threshold 0 passes single-sample pulses
    min_width = 8'd0;
    for (int k = 0; k < 6; k++) hold((k % 2) ? 6'b101010 : 6'b010101, 1'b1, 1, "R3");
    hold('0, 1'b1, 3, "R3");
    // R4: gate off holds outputs low while the filters run
    min_width = 8'd2;
    hold(6'b111111, 1'b0, 6, "R4");
    // R5: release shows filtered state in the same cycle
    step(6'b111111, 1'b1, 1'b0, "R5");
    #1;
    checks++;
    if (pwm_out !== 6'b111111) begin
      errors++;
      $display("FAIL R5: pwm_out=%b expected=%b right after release", pwm_out, 6'b111111);
    end
    hold(6'b111111, 1'b1, 2, "R5");
    hold('0, 1'b1, 3, "R5");
    // R5: runt pulse after release (one cycle at threshold 2)
    hold(6'b000011, 1'b0, 3, "R5");
    hold(6'b000011, 1'b1, 1, "R5");
    hold('0, 1'b1, 3, "R5");
    // R6: reset in the middle of a pulse restarts the count
    min_width = 8'd1;
    hold(6'b110000, 1'b1, 3, "R6");
    step(6'b110000, 1'b1, 1'b1, "R6");
    hold(6'b110000, 1'b1, 3, "R6");
    hold('0, 1'b1, 3, "R6");
    // R8: saturation at the largest threshold
    min_width = 8'd255;
    hold(6'b001000, 1'b1, 300, "R8");
    hold('0, 1'b1, 3, "R8");
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule